// File: doc/BRIEF.md
# UART FIFO and Interrupt Register Front End

This block is the byte-wide, memory-mapped register side of a serial port. A host reads and writes byte registers on a 5-bit address. Behind them sit a transmit FIFO and a receive FIFO, each 16 entries deep. The block also holds the port enable, the direction enables, the frame configuration byte, a 16-bit baud divisor and a FIFO configuration register. An interrupt unit keeps one flag for the transmit source and one for the receive source. Each flag can be raised by hardware, raised by software, or cleared by software, and each has its own enable. The flags combine into a single interrupt line.

On its far side the block talks to a frame transceiver through two byte streams. Transmit bytes leave through a valid/ready pair. Received bytes arrive with three error bits per character, and the block stores those bits next to the byte in the receive FIFO. The serial framing is not done here. The frame configuration byte and the divisor are only held and driven out to the transceiver.

The receive threshold is a 3-bit field that the block adds to half the FIFO depth. Because of this, the receive condition can never be set below half full. The bus reads data combinationally in the cycle the read strobe is high, and a read of the data address pops the receive FIFO at the next clock edge.

Top module: `uart_regif`

## Requirements
- R1: After reset, all registers read 0 except the FIFO status register, which reads 0x84 (receive empty and transmit almost-empty). `irq_o` and `tx_valid_o` are low, and a data read returns 0.
- R2: The register map is as follows. Address 0x00 bit 0 is the port enable. Address 0x01 bit 0 is the receive enable and bit 1 is the transmit enable. Address 0x03 is the 8-bit frame configuration. Addresses 0x08 and 0x09 are the low and high divisor bytes. Address 0x0B holds the threshold in bits [2:0], the receive FIFO mode in bit 3 and the transmit FIFO mode in bit 7; its other bits read 0. Address 0x1E bits [1:0] are the interrupt enables. The flag-clear (0x1C) and flag-set (0x1D) addresses read 0. `frame_cfg_o`, `divisor_o`, `port_en_o`, `rx_en_o` and `tx_en_o` mirror the stored values.
- R3: A write to address 0x04 appends a byte to the transmit FIFO. `tx_valid_o` is high while the port enable, the transmit enable and a non-empty FIFO all hold. `tx_data_o` shows the oldest byte, which is removed on a cycle with `tx_valid_o` and `tx_ready_i` both high, so bytes leave in write order.
- R4: With the port enable and the receive enable set, `rx_valid_i` stores `rx_data_i` together with `rx_err_i` in the receive FIFO. A read of address 0x04 returns the oldest byte and removes it. After that read, address 0x02 bits [2:0] show that byte's error bits: bit 0 is parity, bit 1 is framing, bit 2 is overrun.
- R5: A push into a full FIFO is dropped. Fullness is judged on the level at the start of the cycle, even if a pop happens in the same cycle. A data read on an empty receive FIFO returns the last byte popped, and changes neither the FIFO nor the error bits.
- R6: With its mode bit set, a FIFO holds 16 entries. With the mode bit clear, it holds a single entry.
- R7: The FIFO status register at 0x0A reports four conditions. Bit 2 is receive empty. Bit 4 is transmit full. Bit 7 is transmit almost-empty, meaning at most 4 entries. Bit 3 is the receive condition: in FIFO mode it means the level is above 8 plus the threshold, and in single-entry mode it means not empty.
- R8: The TX flag (bit 0) is set one cycle after the transmit FIFO enters the almost-empty state from above it. It is not set again while the FIFO stays in that state.
- R9: The RX flag (bit 1) is set in every cycle after a cycle in which the receive condition held.
- R10: Writing 1s to 0x1D sets flags and writing 1s to 0x1C clears them. A hardware set in the same cycle as a clear wins, so the flag stays set.
- R11: `irq_o` is the port enable ANDed with the OR of the flags masked by their enables. Address 0x1F reads the unmasked flags.
- R12: A write to 0x01 with bit 2 set empties both FIFOs, clears the flags, the error bits and the last-byte value, and stores bits [1:0] as the direction enables. It keeps the configuration, the divisor, the port enable and the interrupt enables. Bit 2 reads back as 0.
- R13: With the port enable at 0, `tx_valid_o` and `irq_o` stay low and received bytes are ignored. Register reads and writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Transceiver takes the byte |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 3 | Received byte error bits (parity, framing, overrun) |
| rx_valid_i | input | 1 | Received byte strobe |
| port_en_o | output | 1 | Port enable |
| rx_en_o | output | 1 | Receive enable |
| tx_en_o | output | 1 | Transmit enable |
| frame_cfg_o | output | 8 | Frame configuration byte |
| divisor_o | output | 16 | Baud divisor |
| irq_o | output | 1 | Interrupt request |

## Verification
Two kinds of same-cycle collision matter most here.

The first is on the receive FIFO: a bus read pops it while the transceiver pushes into it. The bench provokes this with a combined read-and-push at a middling level and again at full. At a middling level the level must stay the same and the order must be kept. At full the pushed byte must be lost.

The second is in the interrupt unit: a software clear lands while the hardware receive condition is still true. The bench clears the RX flag with the FIFO above threshold and expects the flag to read back set. A behavioural model with queues predicts every read, `irq_o` and the transmit stream on every clock.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_ENABLE   = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL     = 5'h01;
  localparam logic [ADDR_W-1:0] A_STAT     = 5'h02;
  localparam logic [ADDR_W-1:0] A_CFG      = 5'h03;
  localparam logic [ADDR_W-1:0] A_DATA     = 5'h04;
  localparam logic [ADDR_W-1:0] A_DIV_LO   = 5'h08;
  localparam logic [ADDR_W-1:0] A_DIV_HI   = 5'h09;
  localparam logic [ADDR_W-1:0] A_FSTAT    = 5'h0A;
  localparam logic [ADDR_W-1:0] A_FCFG     = 5'h0B;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 5'h1C;
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = 5'h1D;
  localparam logic [ADDR_W-1:0] A_IRQ_EN   = 5'h1E;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 5'h1F;

  localparam int IRQ_N  = 2;
  localparam int IRQ_TX = 0;
  localparam int IRQ_RX = 1;

  typedef struct packed {
    logic       tx_mode;
    logic       rx_mode;
    logic [2:0] thr;
  } fcfg_t;
endpackage

// File: rtl/uart_regif_fifo.sv
// Circular buffer; DEPTH must be a power of two.
module uart_regif_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     single_i,
  input  logic                     push_i,
  input  logic [WIDTH-1:0]         push_data_i,
  input  logic                     pop_i,
  output logic [WIDTH-1:0]         head_o,
  output logic [$clog2(DEPTH):0]   level_o,
  output logic                     empty_o,
  output logic                     full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_ptr_q, wr_ptr_q;
  logic [LW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = single_i ? (cnt_q != '0) : (cnt_q == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
  end
endmodule

// File: rtl/uart_regif_irq.sv
// Flag bank: hardware and software sets dominate a software clear.
module uart_regif_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         clr_i,
  input  logic         set_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] hw_set_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, clr_mask, set_mask;

  assign clr_mask = clr_i ? wdata_i : '0;
  assign set_mask = set_i ? wdata_i : '0;
  assign flags_o  = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (flush_i) flags_q <= '0;
    else              flags_q <= (flags_q & ~clr_mask) | set_mask | hw_set_i;
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int ERR_W    = 3,
  parameter int AE_LEVEL = 4,
  parameter int DIV_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [4:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  input  logic              rx_valid_i,
  output logic              port_en_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic [7:0]        frame_cfg_o,
  output logic [DIV_W-1:0]  divisor_o,
  output logic              irq_o
);
  localparam int LW   = $clog2(DEPTH) + 1;
  localparam int RX_W = BYTE_W + ERR_W;
  localparam int HALF = DEPTH / 2;

  logic              en_q, rx_en_q, tx_en_q, tx_ae_prev_q;
  logic [7:0]        cfg_q, last_q;
  logic [DIV_W-1:0]  div_q;
  fcfg_t             fcfg_q;
  logic [IRQ_N-1:0]  ien_q, irq_flags, hw_set;
  logic [ERR_W-1:0]  err_q;

  logic              wr_ctrl, soft_rst, wr_data, rd_data;
  logic [LW-1:0]     tx_level, rx_level;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_ae, rx_above, rx_pop_ok;
  logic [RX_W-1:0]   rx_head;

  assign wr_ctrl  = bus_wr_i && (bus_addr_i == A_CTRL);
  assign soft_rst = wr_ctrl && bus_wdata_i[2];
  assign wr_data  = bus_wr_i && (bus_addr_i == A_DATA);
  assign rd_data  = bus_rd_i && (bus_addr_i == A_DATA);
  assign rx_pop_ok = rd_data && !rx_empty;

  // Transmit path
  uart_regif_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) tx_fifo_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (soft_rst),
    .single_i    (!fcfg_q.tx_mode),
    .push_i      (wr_data),
    .push_data_i (bus_wdata_i),
    .pop_i       (tx_valid_o && tx_ready_i),
    .head_o      (tx_data_o),
    .level_o     (tx_level),
    .empty_o     (tx_empty),
    .full_o      (tx_full)
  );

  assign tx_valid_o = en_q && tx_en_q && !tx_empty;

  // Receive path, error bits stored above the byte
  uart_regif_fifo #(.DEPTH(DEPTH), .WIDTH(RX_W)) rx_fifo_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (soft_rst),
    .single_i    (!fcfg_q.rx_mode),
    .push_i      (en_q && rx_en_q && rx_valid_i),
    .push_data_i ({rx_err_i, rx_data_i}),
    .pop_i       (rd_data),
    .head_o      (rx_head),
    .level_o     (rx_level),
    .empty_o     (rx_empty),
    .full_o      (rx_full)
  );

  // Threshold is offset by half the depth so it never drops below half full
  assign rx_above = fcfg_q.rx_mode ? (rx_level > (LW'(HALF) + LW'(fcfg_q.thr))) : !rx_empty;
  assign tx_ae    = (tx_level <= LW'(AE_LEVEL));

  always_comb begin
    hw_set         = '0;
    hw_set[IRQ_TX] = tx_ae && !tx_ae_prev_q;
    hw_set[IRQ_RX] = rx_above;
  end

  uart_regif_irq #(.N(IRQ_N)) irq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (soft_rst),
    .clr_i    (bus_wr_i && (bus_addr_i == A_IRQ_CLR)),
    .set_i    (bus_wr_i && (bus_addr_i == A_IRQ_SET)),
    .wdata_i  (bus_wdata_i[IRQ_N-1:0]),
    .hw_set_i (hw_set),
    .flags_o  (irq_flags)
  );

  assign irq_o = en_q && |(irq_flags & ien_q);

  // Configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      cfg_q   <= '0;
      div_q   <= '0;
      fcfg_q  <= '0;
      ien_q   <= '0;
    end else if (bus_wr_i) begin
      unique case (bus_addr_i)
        A_ENABLE: en_q <= bus_wdata_i[0];
        A_CTRL: begin
          rx_en_q <= bus_wdata_i[0];
          tx_en_q <= bus_wdata_i[1];
        end
        A_CFG:    cfg_q <= bus_wdata_i;
        A_DIV_LO: div_q[7:0] <= bus_wdata_i;
        A_DIV_HI: div_q[DIV_W-1:8] <= bus_wdata_i[DIV_W-9:0];
        A_FCFG: begin
          fcfg_q.tx_mode <= bus_wdata_i[7];
          fcfg_q.rx_mode <= bus_wdata_i[3];
          fcfg_q.thr     <= bus_wdata_i[2:0];
        end
        A_IRQ_EN: ien_q <= bus_wdata_i[IRQ_N-1:0];
        default: ;
      endcase
    end
  end

  // Popped-byte state and edge detector for the TX source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q        <= '0;
      last_q       <= '0;
      tx_ae_prev_q <= 1'b1;
    end else if (soft_rst) begin
      err_q        <= '0;
      last_q       <= '0;
      tx_ae_prev_q <= 1'b1;
    end else begin
      tx_ae_prev_q <= tx_ae;
      if (rx_pop_ok) begin
        last_q <= rx_head[BYTE_W-1:0];
        err_q  <= rx_head[RX_W-1:BYTE_W];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_ENABLE:   bus_rdata_o = {7'b0, en_q};
      A_CTRL:     bus_rdata_o = {6'b0, tx_en_q, rx_en_q};
      A_STAT:     bus_rdata_o = {{(BYTE_W-ERR_W){1'b0}}, err_q};
      A_CFG:      bus_rdata_o = cfg_q;
      A_DATA:     bus_rdata_o = rx_empty ? last_q : rx_head[BYTE_W-1:0];
      A_DIV_LO:   bus_rdata_o = div_q[7:0];
      A_DIV_HI:   bus_rdata_o = div_q[DIV_W-1:8];
      A_FSTAT:    bus_rdata_o = {tx_ae, 2'b0, tx_full, rx_above, rx_empty, 2'b0};
      A_FCFG:     bus_rdata_o = {fcfg_q.tx_mode, 3'b0, fcfg_q.rx_mode, fcfg_q.thr};
      A_IRQ_EN:   bus_rdata_o = {6'b0, ien_q};
      A_IRQ_STAT: bus_rdata_o = {6'b0, irq_flags};
      default:    bus_rdata_o = '0;
    endcase
  end

  assign port_en_o   = en_q;
  assign rx_en_o     = rx_en_q;
  assign tx_en_o     = tx_en_q;
  assign frame_cfg_o = cfg_q;
  assign divisor_o   = div_q;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bus_wr_i,
  input logic [4:0]             bus_addr_i,
  input logic [7:0]             bus_wdata_i,
  input logic                   tx_valid_o,
  input logic                   tx_ready_i,
  input logic [7:0]             tx_data_o,
  input logic                   irq_o,
  input logic [1:0]             flags,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic [$clog2(DEPTH):0] tx_level
);
  AST_RX_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level <= ($clog2(DEPTH)+1)'(DEPTH));  // R5

  AST_TX_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level <= ($clog2(DEPTH)+1)'(DEPTH));  // R6

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !bus_wr_i |=> tx_valid_o && $stable(tx_data_o));  // R3

  AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == 5'h00 && !bus_wdata_i[0] |=> !irq_o && !tx_valid_o);  // R13

  AST_SOFT_RESET_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == 5'h01 && bus_wdata_i[2] |=> rx_level == '0 && tx_level == '0 && flags == '0);  // R12

  AST_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == 5'h1D |=> (flags & $past(bus_wdata_i[1:0])) == $past(bus_wdata_i[1:0]));  // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags != 2'b00);  // R11
endmodule

bind uart_regif uart_regif_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .tx_data_o   (tx_data_o),
  .irq_o       (irq_o),
  .flags       (irq_flags),
  .rx_level    (rx_level),
  .tx_level    (tx_level)
);

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [2:0]  rx_err = '0;
  logic        rx_valid = 1'b0;
  logic        port_en, rx_en, tx_en, irq;
  logic [7:0]  frame_cfg;
  logic [15:0] divisor;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_err_i(rx_err), .rx_valid_i(rx_valid),
    .port_en_o(port_en), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .frame_cfg_o(frame_cfg), .divisor_o(divisor), .irq_o(irq)
  );

  // Reference model state
  logic        m_en, m_rxen, m_txen, m_prev;
  logic [7:0]  m_cfg, m_fcfg, m_last;
  logic [15:0] m_div;
  logic [1:0]  m_ien, m_flags;
  logic [2:0]  m_err;
  logic [10:0] rxq[$];
  logic [7:0]  txq[$];

  function automatic int cap(input logic mode);
    return mode ? 16 : 1;
  endfunction
  function automatic bit m_rxabove();
    if (m_fcfg[3]) return rxq.size() > 8 + int'(m_fcfg[2:0]);
    return rxq.size() != 0;
  endfunction
  function automatic bit m_txae();
    return txq.size() <= 4;
  endfunction
  function automatic bit m_txvalid();
    return m_en && m_txen && txq.size() > 0;
  endfunction
  function automatic bit m_irq();
    return m_en && |(m_flags & m_ien);
  endfunction
  function automatic logic [7:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return {7'b0, m_en};
      5'h01: return {6'b0, m_txen, m_rxen};
      5'h02: return {5'b0, m_err};
      5'h03: return m_cfg;
      5'h04: return (rxq.size() > 0) ? rxq[0][7:0] : m_last;
      5'h08: return m_div[7:0];
      5'h09: return m_div[15:8];
      5'h0A: return {m_txae(), 2'b0, txq.size() >= cap(m_fcfg[7]), m_rxabove(), rxq.size() == 0, 2'b0};
      5'h0B: return m_fcfg;
      5'h1E: return {6'b0, m_ien};
      5'h1F: return {6'b0, m_flags};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit txf, rxf, tv, ra, ta;
    logic [1:0] hw, clr, set;
    logic [10:0] e;
    if (!rst_n) begin
      m_en = 0; m_rxen = 0; m_txen = 0; m_prev = 1;
      m_cfg = 0; m_fcfg = 0; m_last = 0; m_div = 0;
      m_ien = 0; m_flags = 0; m_err = 0;
      rxq.delete(); txq.delete();
    end else begin
      txf = txq.size() >= cap(m_fcfg[7]);
      rxf = rxq.size() >= cap(m_fcfg[3]);
      tv = m_txvalid(); ra = m_rxabove(); ta = m_txae();
      if (bus_wr && bus_addr == 5'h01 && bus_wdata[2]) begin
        rxq.delete(); txq.delete();
        m_flags = 0; m_err = 0; m_last = 0; m_prev = 1;
        m_rxen = bus_wdata[0]; m_txen = bus_wdata[1];
      end else begin
        hw = {ra, ta && !m_prev};
        m_prev = ta;
        if (tv && tx_ready) void'(txq.pop_front());
        if (bus_wr && bus_addr == 5'h04 && !txf) txq.push_back(bus_wdata);
        if (bus_rd && bus_addr == 5'h04 && rxq.size() > 0) begin
          e = rxq.pop_front();
          m_last = e[7:0]; m_err = e[10:8];
        end
        if (m_en && m_rxen && rx_valid && !rxf) rxq.push_back({rx_err, rx_data});
        clr = (bus_wr && bus_addr == 5'h1C) ? bus_wdata[1:0] : 2'b0;
        set = (bus_wr && bus_addr == 5'h1D) ? bus_wdata[1:0] : 2'b0;
        m_flags = (m_flags & ~clr) | set | hw;
        if (bus_wr) case (bus_addr)
          5'h00: m_en = bus_wdata[0];
          5'h01: begin m_rxen = bus_wdata[0]; m_txen = bus_wdata[1]; end
          5'h03: m_cfg = bus_wdata;
          5'h08: m_div[7:0] = bus_wdata;
          5'h09: m_div[15:8] = bus_wdata;
          5'h0B: m_fcfg = bus_wdata & 8'h8F;
          5'h1E: m_ien = bus_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 irq_o", irq, m_irq());
      chk("R3 tx_valid_o", tx_valid, m_txvalid());
      if (m_txvalid()) chk("R3 tx_data_o", tx_data, txq[0]);
    end
  end

  task automatic clr_in();
    bus_wr = 0; bus_rd = 0; rx_valid = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); clr_in(); end
  endtask
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); clr_in();
    bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask
  task automatic rd(input logic [4:0] a, input string req);
    @(negedge clk); clr_in();
    bus_rd = 1; bus_addr = a;
    #1 chk(req, bus_rdata, m_read(a));
  endtask
  task automatic rx_push(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk); clr_in();
    rx_valid = 1; rx_data = d; rx_err = e;
  endtask
  task automatic rd_push(input logic [7:0] d, input string req);
    @(negedge clk); clr_in();
    bus_rd = 1; bus_addr = 5'h04; rx_valid = 1; rx_data = d; rx_err = 3'b010;
    #1 chk(req, bus_rdata, m_read(5'h04));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    rd(5'h0A, "R1 fifo status"); rd(5'h00, "R1 enable"); rd(5'h1F, "R1 flags");
    rd(5'h04, "R1 data"); chk("R1 irq_o", irq, 0);
    // R2 register map
    wr(5'h00, 8'h01); wr(5'h01, 8'h03); wr(5'h03, 8'h5A);
    wr(5'h08, 8'h34); wr(5'h09, 8'h12); wr(5'h0B, 8'hFF);
    rd(5'h0B, "R2 fifo cfg mask");
    wr(5'h0B, 8'h88); wr(5'h1E, 8'h03);
    rd(5'h01, "R2 control"); rd(5'h03, "R2 config"); rd(5'h08, "R2 div lo");
    rd(5'h09, "R2 div hi"); rd(5'h1E, "R2 irq enable"); rd(5'h1C, "R2 clear reads 0");
    rd(5'h1D, "R2 set reads 0");
    chk("R2 frame_cfg_o", frame_cfg, 8'h5A); chk("R2 divisor_o", divisor, 16'h1234);
    chk("R2 enables", {port_en, rx_en, tx_en}, 3'b111);
    rd(5'h1F, "R8 no flag while staying almost-empty");
    // R3 / R8 transmit drain
    tx_ready = 0;
    for (int i = 0; i < 6; i++) wr(5'h04, 8'hA0 + 8'(i));
    idle(2); rd(5'h0A, "R7 tx above almost-empty");
    tx_ready = 1; idle(10);
    rd(5'h1F, "R8 tx flag after entering almost-empty");
    wr(5'h1C, 8'h03); rd(5'h1F, "R10 clear");
    // R5 transmit full
    tx_ready = 0;
    for (int i = 0; i < 18; i++) wr(5'h04, 8'h10 + 8'(i));
    rd(5'h0A, "R5 tx full");
    tx_ready = 1; idle(25);
    wr(5'h1C, 8'h03);
    // R4 / R9 receive
    for (int i = 0; i < 9; i++) rx_push(8'h40 + 8'(i), 3'(i));
    idle(1); rd(5'h1F, "R9 rx flag"); rd(5'h0A, "R7 rx above threshold");
    for (int i = 0; i < 3; i++) begin rd(5'h04, "R4 data"); rd(5'h02, "R4 error bits"); end
    rd_push(8'h77, "R4 pop with push");
    rd(5'h0A, "R4 level kept");
    for (int i = 0; i < 6; i++) rx_push(8'h60 + 8'(i), 3'b100);
    idle(1); wr(5'h1C, 8'h02); rd(5'h1F, "R10 hw set beats clear");
    for (int i = 0; i < 6; i++) rx_push(8'h80 + 8'(i), 3'b001);
    rd(5'h0A, "R5 rx full");
    rd_push(8'hEE, "R5 push at full with pop");
    rd(5'h0A, "R5 level after dropped push");
    for (int i = 0; i < 18; i++) begin rd(5'h04, "R5 drain"); rd(5'h02, "R4 drain error"); end
    rd(5'h04, "R5 empty read returns last");
    // R7 threshold at maximum
    wr(5'h0B, 8'h8F);
    for (int i = 0; i < 15; i++) rx_push(8'(i), 3'b000);
    idle(1); rd(5'h0A, "R7 level 15 not above");
    rx_push(8'hF0, 3'b000); idle(1); rd(5'h0A, "R7 level 16 above");
    // R12 soft reset
    tx_ready = 0; wr(5'h04, 8'h5C); wr(5'h04, 8'h5D);
    wr(5'h01, 8'h07);
    rd(5'h0A, "R12 fifos empty"); rd(5'h1F, "R12 flags clear"); rd(5'h02, "R12 errors clear");
    rd(5'h04, "R12 last clear"); rd(5'h01, "R12 control"); rd(5'h0B, "R12 fifo cfg kept");
    rd(5'h09, "R12 divisor kept"); rd(5'h1E, "R12 irq enable kept");
    // R6 single-entry mode
    wr(5'h0B, 8'h00);
    rx_push(8'h11, 3'b000); rx_push(8'h22, 3'b000);
    rd(5'h0A, "R6 rx single"); rd(5'h04, "R6 first kept"); rd(5'h04, "R6 second dropped");
    wr(5'h04, 8'h33); wr(5'h04, 8'h44); rd(5'h0A, "R6 tx single full");
    tx_ready = 1; idle(3);
    wr(5'h1C, 8'h03);
    // R10 software set
    wr(5'h1D, 8'h01); rd(5'h1F, "R10 set tx"); wr(5'h1C, 8'h01); rd(5'h1F, "R10 clear tx");
    // R13 port disable
    tx_ready = 0; wr(5'h04, 8'h55); wr(5'h1D, 8'h03); wr(5'h00, 8'h00); idle(2);
    rx_push(8'h99, 3'b000); idle(1);
    rd(5'h0A, "R13 rx ignored"); rd(5'h1F, "R13 flags readable");
    tx_ready = 1; idle(3); rd(5'h0A, "R13 tx held");
    wr(5'h00, 8'h01); idle(4);
    rd(5'h0A, "R13 tx drains after enable");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule